// File: doc/BRIEF.md
# Register Save/Restore Sequencer with Stack Guard Word

This block executes one save-multiple (function entry) or restore-multiple (function exit) operation on a stack that grows toward lower addresses. It moves one 64-bit word per cycle between the register file and memory. An operation names a contiguous register span by an upper and a lower 6-bit index, and three option bits select whether the return-address register, the global-data pointer register and a guard word take part.

The guard word is a per-program secret XORed with the address of the stack slot that holds it. Each frame therefore carries a different value. On restore the guard word is read and compared before any register is touched. A mismatch aborts the operation with a fault, and the register file and stack pointer are left as they were.

A control enable input lets software turn the guard word off globally. The secret is loaded through its own write port.

Top module: `lsm_seq`

## Requirements
- R1: After reset, busy, done, fault, spWe, memReq and rfWe are all low.
- R2: A save pushes words in this order: register 1 (return address) when the return-address flag is set, then register 3 (global pointer) when the global-pointer flag is set, then registers from the upper index down to the lower index, then the guard word when the guard flag is set. The stack pointer is decremented by 8 before each write, so the first write goes to SP-8 and the addresses fall by 8 per word.
- R3: The register span is moved only when upper index >= lower index. Otherwise no span register is transferred.
- R4: The guard word written equals secret XOR the address it is stored at. The secret is the value last written through secretWe/secretData.
- R5: A restore reads words in the exact reverse order: guard word, then the span from the lower index up to the upper index, then register 3, then register 1. Each flag condition matches the one used by the save. The first read is at SP and the addresses rise by 8 per word. Each restored register is written with the word read in that cycle, and the guard word itself writes no register.
- R6: When the guard word read on restore differs from secret XOR its address, fault and done are high together for one cycle. No register-file write occurs during the whole operation, and spWe stays low, so the stack pointer keeps its value from before the operation.
- R7: On a completed operation without fault, spWe pulses together with done. spOut then equals the start SP minus 8 per word saved, or plus 8 per word restored.
- R8: busy is high for exactly one cycle per word transferred, with one memory access in each such cycle. done pulses for one cycle right after the last transfer. A start raised while the block is not idle is ignored.
- R9: When canaryEn is low, the guard flag acts as zero on both save and restore.
- R10: An operation with no flags set and upper index < lower index raises done in the cycle after start, with no busy cycle and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Operation request, accepted only when idle |
| isLoad | input | 1 | 1 = restore, 0 = save |
| hiIdx | input | 6 | Upper register index of the span |
| loIdx | input | 6 | Lower register index of the span |
| flagLr | input | 1 | Include return-address register |
| flagGp | input | 1 | Include global-pointer register |
| flagSk | input | 1 | Include guard word |
| canaryEn | input | 1 | Global enable for the guard word |
| secretWe | input | 1 | Load strobe for the guard secret |
| secretData | input | 64 | Guard secret value |
| spIn | input | 64 | Stack pointer at start |
| spOut | output | 64 | Updated stack pointer |
| spWe | output | 1 | Stack pointer update strobe |
| rfAddr | output | 6 | Register-file index for read and write |
| rfRdData | input | 64 | Register-file read data (combinational) |
| rfWe | output | 1 | Register-file write enable |
| rfWrData | output | 64 | Register-file write data |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | Memory write (else read) |
| memAddr | output | 64 | Memory byte address |
| memWdata | output | 64 | Memory write data |
| memRdata | input | 64 | Memory read data (combinational) |
| busy | output | 1 | A transfer happens this cycle |
| done | output | 1 | Operation finished (one cycle) |
| fault | output | 1 | Guard word mismatch (with done) |

## Verification
The hardest case to reach from the ports is a guard mismatch on restore, because a frame saved by the block itself always carries a correct guard word. The bench therefore saves a full frame and then flips one bit of the stored guard word in its own memory model. It clears the span registers and issues the matching restore. The bench then confirms that only the guard read occurs, that fault arrives with done, and that the cleared registers and the stack pointer are untouched. A second hard case is a start arriving mid-operation. The bench raises start during a busy cycle with the opposite direction and shows that the transfer stream is unchanged.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {PH_LR = 2'd0, PH_GP = 2'd1, PH_RNG = 2'd2, PH_CAN = 2'd3} phase_e;

  typedef struct packed {
    logic capture;
    logic load;
    logic xfer;
    logic memWe;
    logic rfWe;
    logic selCanary;
  } strobe_t;
endpackage

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
#(
  parameter int RIDX_W = 6,
  parameter int LR_IDX = 1,
  parameter int GP_IDX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isLoad,
  input  logic [RIDX_W-1:0] hiIdx,
  input  logic [RIDX_W-1:0] loIdx,
  input  logic              flagLr,
  input  logic              flagGp,
  input  logic              flagSk,
  input  logic              canaryEn,
  input  logic              canaryBad,
  output strobe_t           strb,
  output logic [RIDX_W-1:0] regIdx,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              spWe
);
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_FIN} state_e;

  state_e            state;
  logic [1:0]        slot;
  logic [RIDX_W-1:0] cur, hiQ, loQ;
  logic [3:0]        maskQ;
  logic              opLoad, faultQ;

  logic [3:0]  startMask;
  logic        startFound, nextFound;
  logic [1:0]  startSlot, nextSlot;
  phase_e      phase;
  logic        rangeLast;

  // phase that a slot maps to; restore walks the save order backwards
  function automatic phase_e slotPhase(input logic ld, input logic [1:0] s);
    return phase_e'(ld ? (2'd3 - s) : s);
  endfunction

  always_comb begin
    startMask         = '0;
    startMask[PH_LR]  = flagLr;
    startMask[PH_GP]  = flagGp;
    startMask[PH_RNG] = (hiIdx >= loIdx);
    startMask[PH_CAN] = flagSk & canaryEn;
  end

  always_comb begin
    startFound = 1'b0;
    startSlot  = 2'd0;
    for (int k = 3; k >= 0; k--) begin
      if (startMask[slotPhase(isLoad, 2'(k))]) begin
        startFound = 1'b1;
        startSlot  = 2'(k);
      end
    end
  end

  always_comb begin
    nextFound = 1'b0;
    nextSlot  = 2'd0;
    for (int k = 3; k >= 0; k--) begin
      if (k > int'(slot) && maskQ[slotPhase(opLoad, 2'(k))]) begin
        nextFound = 1'b1;
        nextSlot  = 2'(k);
      end
    end
  end

  assign phase     = slotPhase(opLoad, slot);
  assign rangeLast = (cur == (opLoad ? hiQ : loQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      slot   <= '0;
      cur    <= '0;
      hiQ    <= '0;
      loQ    <= '0;
      maskQ  <= '0;
      opLoad <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          faultQ <= 1'b0;
          if (start) begin
            opLoad <= isLoad;
            hiQ    <= hiIdx;
            loQ    <= loIdx;
            maskQ  <= startMask;
            slot   <= startSlot;
            cur    <= isLoad ? loIdx : hiIdx;
            state  <= startFound ? ST_XFER : ST_FIN;
          end
        end
        ST_XFER: begin
          if (canaryBad) begin
            faultQ <= 1'b1;
            state  <= ST_FIN;
          end else if (phase == PH_RNG && !rangeLast) begin
            cur <= opLoad ? cur + 1'b1 : cur - 1'b1;
          end else if (nextFound) begin
            slot <= nextSlot;
          end else begin
            state <= ST_FIN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (phase)
      PH_LR:   regIdx = RIDX_W'(LR_IDX);
      PH_GP:   regIdx = RIDX_W'(GP_IDX);
      default: regIdx = cur;
    endcase
  end

  assign busy  = (state == ST_XFER);
  assign done  = (state == ST_FIN);
  assign fault = done & faultQ;
  assign spWe  = done & ~faultQ;

  always_comb begin
    strb.capture   = (state == ST_IDLE) & start;
    strb.load      = opLoad;
    strb.xfer      = busy;
    strb.memWe     = busy & ~opLoad;
    strb.rfWe      = busy & opLoad & (phase != PH_CAN);
    strb.selCanary = (phase == PH_CAN);
  end
endmodule

// File: rtl/lsm_dp.sv
module lsm_dp
  import lsm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [XLEN-1:0] spIn,
  input  logic            secretWe,
  input  logic [XLEN-1:0] secretData,
  input  logic [XLEN-1:0] rfRdData,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  output logic [XLEN-1:0] spOut,
  output logic            canaryBad
);
  localparam int WORD_BYTES = XLEN / 8;
  localparam logic [XLEN-1:0] STEP = XLEN'(WORD_BYTES);

  logic [XLEN-1:0] spWork, secret, guardWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secret <= '0;
    end else if (secretWe) begin
      secret <= secretData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spWork <= '0;
    end else if (strb.capture) begin
      spWork <= spIn;
    end else if (strb.xfer) begin
      spWork <= strb.load ? spWork + STEP : spWork - STEP;
    end
  end

  // save pre-decrements, restore post-increments
  assign memAddr   = strb.load ? spWork : spWork - STEP;
  assign guardWord = secret ^ memAddr;
  assign memWdata  = strb.selCanary ? guardWord : rfRdData;
  assign canaryBad = strb.xfer & strb.load & strb.selCanary & (memRdata != guardWord);
  assign spOut     = spWork;
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 6,
  parameter int LR_IDX = 1,
  parameter int GP_IDX = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isLoad,
  input  logic [RIDX_W-1:0] hiIdx,
  input  logic [RIDX_W-1:0] loIdx,
  input  logic              flagLr,
  input  logic              flagGp,
  input  logic              flagSk,
  input  logic              canaryEn,
  input  logic              secretWe,
  input  logic [XLEN-1:0]   secretData,
  input  logic [XLEN-1:0]   spIn,
  output logic [XLEN-1:0]   spOut,
  output logic              spWe,
  output logic [RIDX_W-1:0] rfAddr,
  input  logic [XLEN-1:0]   rfRdData,
  output logic              rfWe,
  output logic [XLEN-1:0]   rfWrData,
  output logic              memReq,
  output logic              memWe,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN-1:0]   memWdata,
  input  logic [XLEN-1:0]   memRdata,
  output logic              busy,
  output logic              done,
  output logic              fault
);
  strobe_t strb;
  logic    canaryBad;

  lsm_ctrl #(.RIDX_W(RIDX_W), .LR_IDX(LR_IDX), .GP_IDX(GP_IDX)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isLoad(isLoad),
    .hiIdx(hiIdx), .loIdx(loIdx), .flagLr(flagLr), .flagGp(flagGp),
    .flagSk(flagSk), .canaryEn(canaryEn), .canaryBad(canaryBad),
    .strb(strb), .regIdx(rfAddr), .busy(busy), .done(done),
    .fault(fault), .spWe(spWe)
  );

  lsm_dp #(.XLEN(XLEN)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .spIn(spIn),
    .secretWe(secretWe), .secretData(secretData), .rfRdData(rfRdData),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .spOut(spOut), .canaryBad(canaryBad)
  );

  assign memReq   = strb.xfer;
  assign memWe    = strb.memWe;
  assign rfWe     = strb.rfWe;
  assign rfWrData = memRdata;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic fault,
  input logic spWe,
  input logic rfWe,
  input logic memReq,
  input logic memWe
);
  // R8: done lasts a single cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R8: busy ends only into done
  assert_busy_to_done_R8: assert property (@(posedge clk) disable iff (!rstN) (busy && !$past(!rstN)) |=> (busy || done));
  // R8: a memory access happens in every busy cycle and only then
  assert_mem_in_busy_R8: assert property (@(posedge clk) disable iff (!rstN) memReq |-> busy);
  // R6: fault only arrives with done
  assert_fault_with_done_R6: assert property (@(posedge clk) disable iff (!rstN) fault |-> (done && !spWe));
  // R7: stack pointer update only with a clean done
  assert_sp_commit_R7: assert property (@(posedge clk) disable iff (!rstN) spWe |-> (done && !fault));
  // R5: register write only during a read transfer
  assert_rf_write_R5: assert property (@(posedge clk) disable iff (!rstN) rfWe |-> (memReq && !memWe));
  // R1: outputs quiet after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) $rose(rstN) |-> (!busy && !done && !memReq && !rfWe));
endmodule

bind lsm_seq lsm_seq_chk i_chk (.*);

// File: tb/test_lsm_seq.sv
module test_lsm_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, isLoad = 1'b0;
  logic [5:0]  hiIdx = '0, loIdx = '0;
  logic        flagLr = 1'b0, flagGp = 1'b0, flagSk = 1'b0, canaryEn = 1'b1;
  logic        secretWe = 1'b0;
  logic [63:0] secretData = '0;
  logic [63:0] spIn;
  logic [63:0] spOut, rfRdData, rfWrData, memAddr, memWdata, memRdata;
  logic        spWe, rfWe, memReq, memWe, busy, done, fault;
  logic [5:0]  rfAddr;

  logic [63:0] mem [0:127];
  logic [63:0] rf  [0:63];
  logic [63:0] snap [0:63];
  logic [63:0] spReg;
  logic [63:0] secretVal;

  int nChecks = 0, nFails = 0;

  typedef struct {
    logic        wr;
    logic [63:0] addr;
    logic [63:0] data;
    logic        rw;
    logic [5:0]  idx;
    string       req;
  } item_t;
  item_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsm_seq i_lsm_seq (
    .clk(clk), .rstN(rstN), .start(start), .isLoad(isLoad), .hiIdx(hiIdx),
    .loIdx(loIdx), .flagLr(flagLr), .flagGp(flagGp), .flagSk(flagSk),
    .canaryEn(canaryEn), .secretWe(secretWe), .secretData(secretData),
    .spIn(spIn), .spOut(spOut), .spWe(spWe), .rfAddr(rfAddr),
    .rfRdData(rfRdData), .rfWe(rfWe), .rfWrData(rfWrData), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .done(done), .fault(fault)
  );

  assign spIn     = spReg;
  assign rfRdData = rf[rfAddr];
  assign memRdata = mem[memAddr[9:3]];

  always @(posedge clk) begin
    if (memReq && memWe) mem[memAddr[9:3]] <= memWdata;
    if (rfWe) rf[rfAddr] <= rfWrData;
    if (spWe) spReg <= spOut;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: compare every transfer against the scoreboard
  always @(negedge clk) begin
    if (rstN && memReq) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R8", "unexpected transfer at", memAddr, 64'd0);
      end else begin
        item_t e;
        e = expQ.pop_front();
        chk(memWe == e.wr, e.req, "direction", 64'(memWe), 64'(e.wr));
        chk(memAddr == e.addr, e.req, "address", memAddr, e.addr);
        if (e.wr) chk(memWdata == e.data, e.req, "write data", memWdata, e.data);
        chk(rfWe == e.rw, e.req, "rf write enable", 64'(rfWe), 64'(e.rw));
        if (e.rw) begin
          chk(rfAddr == e.idx, e.req, "rf index", 64'(rfAddr), 64'(e.idx));
          chk(rfWrData == e.data, e.req, "rf data", rfWrData, e.data);
        end
      end
    end else if (rstN && rfWe) begin
      chk(1'b0, "R6", "rf write without transfer", 64'(rfAddr), 64'd0);
    end
  end

  function automatic void pushItem(input logic wr, input logic [63:0] a,
                                   input logic [63:0] d, input logic rw,
                                   input logic [5:0] idx, input string req);
    item_t e;
    e.wr = wr; e.addr = a; e.data = d; e.rw = rw; e.idx = idx; e.req = req;
    expQ.push_back(e);
  endfunction

  // build expected save stream; returns word count
  function automatic int expSave(input logic [5:0] hi, input logic [5:0] lo,
                                 input logic lr, input logic gp, input logic sk);
    logic [63:0] a = spReg;
    int n = 0;
    if (lr) begin a -= 8; pushItem(1, a, rf[1], 0, 0, "R2"); n++; end
    if (gp) begin a -= 8; pushItem(1, a, rf[3], 0, 0, "R2"); n++; end
    if (hi >= lo)
      for (int i = int'(hi); i >= int'(lo); i--) begin
        a -= 8; pushItem(1, a, rf[i], 0, 0, "R3"); n++;
      end
    if (sk && canaryEn) begin a -= 8; pushItem(1, a, secretVal ^ a, 0, 0, "R4"); n++; end
    return n;
  endfunction

  function automatic int expRestore(input logic [5:0] hi, input logic [5:0] lo,
                                    input logic lr, input logic gp, input logic sk,
                                    input logic guardOnly);
    logic [63:0] a = spReg;
    int n = 0;
    if (sk && canaryEn) begin pushItem(0, a, 0, 0, 0, "R5"); a += 8; n++; end
    if (guardOnly) return n;
    if (hi >= lo)
      for (int i = int'(lo); i <= int'(hi); i++) begin
        pushItem(0, a, snap[i], 1, 6'(i), "R5"); a += 8; n++;
      end
    if (gp) begin pushItem(0, a, snap[3], 1, 6'd3, "R5"); a += 8; n++; end
    if (lr) begin pushItem(0, a, snap[1], 1, 6'd1, "R5"); n++; end
    return n;
  endfunction

  task automatic runOp(input logic ld, input logic [5:0] hi, input logic [5:0] lo,
                       input logic lr, input logic gp, input logic sk, input logic poke,
                       output int nBusy, output int startToDone,
                       output logic gotFault, output logic gotSpWe);
    @(negedge clk);
    isLoad = ld; hiIdx = hi; loIdx = lo; flagLr = lr; flagGp = gp; flagSk = sk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nBusy = 0;
    startToDone = 1;
    gotFault = 1'b0;
    gotSpWe = 1'b0;
    for (int c = 0; c < 500; c++) begin
      if (done) break;
      if (busy) nBusy++;
      start = poke && (nBusy == 2);
      if (start) isLoad = ~ld;
      @(negedge clk);
      startToDone++;
    end
    start = 1'b0;
    isLoad = ld;
    gotFault = fault;
    gotSpWe = spWe;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int nb, sd, nExp;
    logic gf, gs;
    logic [63:0] spBefore;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    for (int i = 0; i < 64; i++) rf[i] = 64'h1000_0000_0000_0000 + 64'(i) * 64'h0101_0203;
    spReg = 64'h400;
    secretVal = 64'hA5C3_0F96_1234_8EE1;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !spWe && !memReq && !rfWe, "R1", "reset outputs",
        {58'd0, busy, done, fault, spWe, memReq, rfWe}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    secretData = secretVal; secretWe = 1'b1;
    @(negedge clk);
    secretWe = 1'b0;

    // full save: LR, GP, span 12..9, guard
    for (int i = 0; i < 64; i++) snap[i] = rf[i];
    spBefore = spReg;
    nExp = expSave(12, 9, 1, 1, 1);
    runOp(0, 12, 9, 1, 1, 1, 0, nb, sd, gf, gs);
    chk(nb == nExp, "R8", "save busy cycles", 64'(nb), 64'(nExp));
    chk(expQ.size() == 0, "R2", "save stream complete", 64'(expQ.size()), 0);
    chk(gs && !gf, "R7", "save commit", {62'd0, gs, gf}, 64'd2);
    @(negedge clk);
    chk(spReg == spBefore - 64'(8 * nExp), "R7", "sp after save", spReg, spBefore - 64'(8 * nExp));

    // full restore with poked start mid-way
    for (int i = 9; i <= 12; i++) rf[i] = '0;
    rf[1] = '0; rf[3] = '0;
    nExp = expRestore(12, 9, 1, 1, 1, 0);
    runOp(1, 12, 9, 1, 1, 1, 1, nb, sd, gf, gs);
    chk(nb == nExp, "R8", "restore busy cycles with ignored start", 64'(nb), 64'(nExp));
    chk(expQ.size() == 0, "R5", "restore stream complete", 64'(expQ.size()), 0);
    chk(!gf && gs, "R7", "restore commit", {62'd0, gs, gf}, 64'd2);
    @(negedge clk);
    chk(spReg == spBefore, "R7", "sp after restore", spReg, spBefore);
    chk(rf[12] == snap[12] && rf[1] == snap[1], "R5", "registers restored", rf[12], snap[12]);
    @(negedge clk);
    chk(!busy && !done, "R8", "idle after ignored start", {62'd0, busy, done}, 0);

    // guard mismatch
    nExp = expSave(12, 9, 0, 0, 1);
    runOp(0, 12, 9, 0, 0, 1, 0, nb, sd, gf, gs);
    @(negedge clk);
    mem[spReg[9:3]] = mem[spReg[9:3]] ^ 64'h10;
    for (int i = 9; i <= 12; i++) rf[i] = '0;
    spBefore = spReg;
    void'(expRestore(12, 9, 0, 0, 1, 1));
    runOp(1, 12, 9, 0, 0, 1, 0, nb, sd, gf, gs);
    chk(gf && !gs, "R6", "fault with done, no sp write", {62'd0, gf, gs}, 64'd2);
    chk(nb == 1, "R6", "only guard read", 64'(nb), 64'd1);
    @(negedge clk);
    chk(spReg == spBefore, "R6", "sp unchanged after fault", spReg, spBefore);
    chk(rf[9] == 0 && rf[12] == 0, "R6", "span untouched", rf[9], 64'd0);
    chk(!fault && !done, "R6", "fault single cycle", {62'd0, fault, done}, 0);
    spReg = spReg + 64'h20 + 64'h8;
    for (int i = 0; i < 64; i++) rf[i] = 64'h2000_0000_0000_0000 + 64'(i) * 64'h77;

    // empty operation
    spBefore = spReg;
    runOp(0, 2, 5, 0, 0, 0, 0, nb, sd, gf, gs);
    chk(nb == 0 && sd == 1, "R10", "empty completes next cycle", 64'(sd), 64'd1);
    chk(expQ.size() == 0 && gs, "R10", "no access, commit", 64'(gs), 64'd1);
    chk(spReg == spBefore, "R3", "no span moved when hi<lo", spReg, spBefore);

    // span only, single register, lr only
    for (int i = 0; i < 64; i++) snap[i] = rf[i];
    nExp = expSave(7, 7, 1, 0, 0);
    runOp(0, 7, 7, 1, 0, 0, 0, nb, sd, gf, gs);
    chk(nb == 2 && expQ.size() == 0, "R3", "single-register span", 64'(nb), 64'd2);

    // guard disabled
    canaryEn = 1'b0;
    spBefore = spReg;
    nExp = expSave(20, 18, 0, 1, 1);
    runOp(0, 20, 18, 0, 1, 1, 0, nb, sd, gf, gs);
    chk(nb == 4 && expQ.size() == 0, "R9", "no guard on save when disabled", 64'(nb), 64'd4);
    rf[18] = '0; rf[19] = '0; rf[20] = '0; rf[3] = '0;
    @(negedge clk);
    nExp = expRestore(20, 18, 0, 1, 1, 0);
    runOp(1, 20, 18, 0, 1, 1, 0, nb, sd, gf, gs);
    chk(nb == 4 && !gf && gs, "R9", "no guard check on restore", 64'(nb), 64'd4);
    @(negedge clk);
    chk(rf[19] == snap[19] && rf[3] == snap[3], "R9", "restored without guard", rf[19], snap[19]);
    canaryEn = 1'b1;

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule